// File: doc/BRIEF.md
# USB Wrapper Interrupt Aggregator

This block gathers the interrupt sources around a USB controller and presents them to software through a small memory-mapped register set. It has two groups. The main group carries one source, the controller core's interrupt line. The misc group carries ten sources:
- separate rising-edge and falling-edge events for four OTG control signals (drive VBUS, charge VBUS, discharge VBUS and ID pull-up);
- a pulse that marks an OTG event;
- a pulse raised when a DMA-disable flag is cleared.

Each group has four registers: a raw status register that records events whether or not they are enabled, a masked status view, and an enable mask. The enable mask is changed only through a set alias and a clear alias, so software never needs a read-modify-write.

Software enables the sources it wants. When an interrupt output goes high, software reads the masked status and writes the same value back to that address to acknowledge it. Each interrupt output is a level that stays high while any enabled status bit in its group remains set. A system configuration register holds the DMA-disable flag. A 1-to-0 transition of that flag, whether caused by software or by the hardware clear pulse, raises a misc event.

Top module: `usb_wrap_irq`

## Requirements
- R1: After reset, all raw status bits, enable bits and the DMA-disable flag are 0, and both interrupt outputs are low.
- R2: A rising edge on drive/charge/discharge/ID-pull-up sets misc raw bit 13/12/11/8, and a falling edge sets bit 5/4/3/0. Misc raw is read at byte address 0x430. Edges are seen one clock after the input changes.
- R3: A one-cycle `otg_evt_i` pulse sets misc raw bit 16. The DMA-disable flag is read/write at address 0x10, bit 16. Whenever that flag goes from 1 to 0, either by a write of 0 or by a `dma_clr_i` pulse, misc raw bit 17 is set.
- R4: A high `core_irq_i` sets main raw bit 0 (address 0x20). The bit stays set after the input falls.
- R5: Writing 1s to an enable-set address (main 0x28, misc 0x438) ORs those bits into the enable mask. Writing 1s to an enable-clear address (main 0x2C, misc 0x43C) removes them. Zero bits have no effect. Reading either address returns the mask.
- R6: Masked status (main 0x24, misc 0x434) reads as raw status ANDed with the enable mask. Raw status records events even when they are disabled.
- R7: Writing 1s to a masked status address clears those raw bits, whether or not they are enabled. Zero bits have no effect. Raw status addresses are read-only.
- R8: An event arriving in the same cycle as a write that clears its bit leaves the bit set.
- R9: `irq_core_o` and `irq_misc_o` are the OR of their group's masked status. They stay high until the bits are cleared or disabled.
- R10: Unmapped addresses read 0. Bits that have no source read 0 and cannot be enabled: main bits 31..1, misc bits other than 17, 16, 13, 12, 11, 8, 5, 4, 3 and 0, and configuration bits other than 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte address for read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from `addr` |
| core_irq_i | input | 1 | Controller core interrupt level |
| drv_vbus_i | input | 1 | OTG drive-VBUS control |
| chrg_vbus_i | input | 1 | OTG charge-VBUS control |
| dischrg_vbus_i | input | 1 | OTG discharge-VBUS control |
| id_pullup_i | input | 1 | OTG ID pull-up control |
| otg_evt_i | input | 1 | OTG event pulse |
| dma_clr_i | input | 1 | Hardware clear pulse for the DMA-disable flag |
| irq_core_o | output | 1 | Main group interrupt |
| irq_misc_o | output | 1 | Misc group interrupt |

## Verification
An edge event and a software acknowledge of the same status bit can land on one clock edge. So can a high core interrupt line and a write that clears main bit 0. The bench provokes both collisions. It first sets the bit, then in a single cycle drives the input transition and the write-1-to-clear strobe together. It judges the outcome by reading the raw status back and by checking that the interrupt output is still high. A DMA flag cleared by hardware in the cycle of a software write is a third overlap, and it is checked through event bit 17.

// File: rtl/usb_wrap_irq.sv
module usb_wrap_irq #(
  parameter int          ADDR_W    = 12,
  parameter logic [31:0] MISC_IMPL = 32'h0003_3939
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              core_irq_i,
  input  logic              drv_vbus_i,
  input  logic              chrg_vbus_i,
  input  logic              dischrg_vbus_i,
  input  logic              id_pullup_i,
  input  logic              otg_evt_i,
  input  logic              dma_clr_i,
  output logic              irq_core_o,
  output logic              irq_misc_o
);
  localparam logic [ADDR_W-1:0] A_SYS   = ADDR_W'('h010);
  localparam logic [ADDR_W-1:0] A_MRAW  = ADDR_W'('h020);
  localparam logic [ADDR_W-1:0] A_MSTAT = ADDR_W'('h024);
  localparam logic [ADDR_W-1:0] A_MSET  = ADDR_W'('h028);
  localparam logic [ADDR_W-1:0] A_MCLR  = ADDR_W'('h02C);
  localparam logic [ADDR_W-1:0] A_XRAW  = ADDR_W'('h430);
  localparam logic [ADDR_W-1:0] A_XSTAT = ADDR_W'('h434);
  localparam logic [ADDR_W-1:0] A_XSET  = ADDR_W'('h438);
  localparam logic [ADDR_W-1:0] A_XCLR  = ADDR_W'('h43C);

  logic [3:0]  ctl, ctl_q, rise, fall;
  logic        raw_main, en_main, dma_flag, dma_flag_d, dma_evt;
  logic [31:0] raw_misc, en_misc, misc_evt, misc_clr;

  assign ctl  = {drv_vbus_i, chrg_vbus_i, dischrg_vbus_i, id_pullup_i};
  assign rise = ctl & ~ctl_q;
  assign fall = ~ctl & ctl_q;

  always_comb begin
    dma_flag_d = dma_flag;
    if (wr_en && addr == A_SYS) dma_flag_d = wdata[16];
    if (dma_clr_i)              dma_flag_d = 1'b0;
  end
  assign dma_evt = dma_flag & ~dma_flag_d;

  assign misc_evt = {14'b0, dma_evt, otg_evt_i, 2'b0, rise[3:1], 2'b0, rise[0],
                     2'b0, fall[3:1], 2'b0, fall[0]};
  assign misc_clr = (wr_en && addr == A_XSTAT) ? wdata : 32'b0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q    <= '0;
      raw_main <= 1'b0;
      en_main  <= 1'b0;
      raw_misc <= '0;
      en_misc  <= '0;
      dma_flag <= 1'b0;
    end else begin
      ctl_q    <= ctl;
      dma_flag <= dma_flag_d;
      raw_misc <= ((raw_misc & ~misc_clr) | misc_evt) & MISC_IMPL;
      raw_main <= (raw_main & ~(wr_en && addr == A_MSTAT && wdata[0])) | core_irq_i;
      if (wr_en && addr == A_MSET && wdata[0]) en_main <= 1'b1;
      if (wr_en && addr == A_MCLR && wdata[0]) en_main <= 1'b0;
      if (wr_en && addr == A_XSET) en_misc <= en_misc | (wdata & MISC_IMPL);
      if (wr_en && addr == A_XCLR) en_misc <= en_misc & ~wdata;
    end
  end

  always_comb begin
    case (addr)
      A_SYS:           rdata = {15'b0, dma_flag, 16'b0};
      A_MRAW:          rdata = {31'b0, raw_main};
      A_MSTAT:         rdata = {31'b0, raw_main & en_main};
      A_MSET, A_MCLR:  rdata = {31'b0, en_main};
      A_XRAW:          rdata = raw_misc;
      A_XSTAT:         rdata = raw_misc & en_misc;
      A_XSET, A_XCLR:  rdata = en_misc;
      default:         rdata = 32'b0;
    endcase
  end

  assign irq_core_o = raw_main & en_main;
  assign irq_misc_o = |(raw_misc & en_misc);

  assert_reset_R1: assert property (@(posedge clk)
    !rst_n |=> (raw_misc == 32'b0 && !raw_main && en_misc == 32'b0 && !en_main && !dma_flag));

  assert_rise_drv_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_vbus_i && !ctl_q[3]) |=> raw_misc[13]);

  assert_fall_idp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!id_pullup_i && ctl_q[0]) |=> raw_misc[0]);

  assert_dma_evt_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dma_flag) |-> raw_misc[17]);

  assert_core_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    core_irq_i |=> raw_main);

  assert_en_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_XSET) |=> ((en_misc & $past(wdata & MISC_IMPL)) == $past(wdata & MISC_IMPL)));

  assert_en_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_XCLR) |=> ((en_misc & $past(wdata)) == 32'b0));

  assert_en_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(en_misc) && $stable(en_main)));

  assert_irq_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_misc_o && !wr_en) |=> irq_misc_o);
endmodule

// File: tb/tb_usb_wrap_irq.sv
module tb_usb_wrap_irq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic core_irq_i = 0, drv = 0, chrg = 0, dis = 0, idp = 0, otg_evt = 0, dma_clr = 0;
  logic irq_core_o, irq_misc_o;
  int   n_chk = 0, n_fail = 0;
  bit   done = 0;

  usb_wrap_irq dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .core_irq_i(core_irq_i), .drv_vbus_i(drv), .chrg_vbus_i(chrg),
    .dischrg_vbus_i(dis), .id_pullup_i(idp), .otg_evt_i(otg_evt), .dma_clr_i(dma_clr),
    .irq_core_o(irq_core_o), .irq_misc_o(irq_misc_o));

  always #4 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [11:0] a, logic [31:0] exp);
    addr = a; #1; chk(req, rdata, exp);
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic t_reset();
    rd_chk("R1 misc raw", 12'h430, 0);
    rd_chk("R1 main raw", 12'h020, 0);
    rd_chk("R1 misc en", 12'h438, 0);
    rd_chk("R1 main en", 12'h028, 0);
    rd_chk("R1 sysconfig", 12'h010, 0);
    chk("R1 irq outputs", {30'b0, irq_core_o, irq_misc_o}, 0);
  endtask

  task automatic t_edges();
    @(negedge clk); drv = 1; chrg = 1; dis = 1; idp = 1;
    tick();
    rd_chk("R2 rising edges", 12'h430, 32'h0000_3900);
    wr(12'h434, 32'h3900);
    rd_chk("R2 cleared", 12'h430, 0);
    drv = 0; chrg = 0; dis = 0; idp = 0;
    tick();
    rd_chk("R2 falling edges", 12'h430, 32'h0000_0039);
    wr(12'h434, 32'hFFFF_FFFF);
    @(negedge clk); chrg = 1;
    tick();
    rd_chk("R2 single rise chrg", 12'h430, 32'h0000_1000);
    chrg = 0;
    tick();
    rd_chk("R2 then fall chrg", 12'h430, 32'h0000_1010);
    wr(12'h434, 32'hFFFF_FFFF);
  endtask

  task automatic t_otg_dma();
    @(negedge clk); otg_evt = 1;
    @(negedge clk); otg_evt = 0;
    rd_chk("R3 otg event", 12'h430, 32'h0001_0000);
    wr(12'h010, 32'hFFFF_FFFF);
    rd_chk("R3 flag set readback", 12'h010, 32'h0001_0000);
    rd_chk("R3 no event on set", 12'h430, 32'h0001_0000);
    wr(12'h010, 32'h0);
    rd_chk("R3 sw clear event", 12'h430, 32'h0003_0000);
    wr(12'h434, 32'hFFFF_FFFF);
    wr(12'h010, 32'h0001_0000);
    @(negedge clk); dma_clr = 1;
    @(negedge clk); dma_clr = 0;
    rd_chk("R3 hw clear flag", 12'h010, 0);
    rd_chk("R3 hw clear event", 12'h430, 32'h0002_0000);
    wr(12'h434, 32'hFFFF_FFFF);
    wr(12'h010, 32'h0001_0000);
    @(negedge clk); addr = 12'h010; wdata = 32'h0001_0000; wr_en = 1; dma_clr = 1;
    @(negedge clk); wr_en = 0; dma_clr = 0;
    rd_chk("R3 hw clear beats write", 12'h010, 0);
    rd_chk("R3 event on overlap", 12'h430, 32'h0002_0000);
    wr(12'h434, 32'hFFFF_FFFF);
  endtask

  task automatic t_core();
    @(negedge clk); core_irq_i = 1;
    @(negedge clk); core_irq_i = 0;
    tick();
    rd_chk("R4 core sticky", 12'h020, 1);
    rd_chk("R6 main masked off", 12'h024, 0);
    chk("R9 core irq low when disabled", {31'b0, irq_core_o}, 0);
    wr(12'h028, 1);
    rd_chk("R5 main enable", 12'h02C, 1);
    chk("R9 core irq", {31'b0, irq_core_o}, 1);
    wr(12'h020, 1);
    rd_chk("R7 raw read-only", 12'h020, 1);
    wr(12'h024, 1);
    rd_chk("R7 main w1c", 12'h020, 0);
    chk("R9 core irq released", {31'b0, irq_core_o}, 0);
    @(negedge clk); core_irq_i = 1;
    @(negedge clk); addr = 12'h024; wdata = 1; wr_en = 1;
    @(negedge clk); wr_en = 0; core_irq_i = 0;
    rd_chk("R8 core level beats clear", 12'h020, 1);
    chk("R8 core irq held", {31'b0, irq_core_o}, 1);
    wr(12'h024, 1);
    wr(12'h02C, 1);
    rd_chk("R5 main disable", 12'h028, 0);
  endtask

  task automatic t_enable();
    wr(12'h438, 32'h0003_0100);
    rd_chk("R5 set", 12'h438, 32'h0003_0100);
    wr(12'h438, 32'h0000_0001);
    rd_chk("R5 set ors", 12'h438, 32'h0003_0101);
    wr(12'h43C, 32'h0001_0000);
    rd_chk("R5 clear", 12'h43C, 32'h0002_0101);
    wr(12'h438, 32'h0);
    wr(12'h43C, 32'h0);
    rd_chk("R5 zeros no effect", 12'h438, 32'h0002_0101);
    wr(12'h438, 32'hFFFF_FFFF);
    rd_chk("R10 only sources enable", 12'h438, 32'h0003_3939);
    wr(12'h43C, 32'hFFFF_FFFF);
    rd_chk("R5 clear all", 12'h438, 0);
  endtask

  task automatic t_masked();
    wr(12'h438, 32'h0000_0100);
    @(negedge clk); idp = 1; drv = 1;
    tick();
    rd_chk("R6 raw unmasked", 12'h430, 32'h0000_2100);
    rd_chk("R6 masked", 12'h434, 32'h0000_0100);
    chk("R9 misc irq", {31'b0, irq_misc_o}, 1);
    wr(12'h434, 32'h0000_0100);
    rd_chk("R7 partial clear", 12'h430, 32'h0000_2000);
    chk("R9 misc irq drops", {31'b0, irq_misc_o}, 0);
    wr(12'h434, 32'h0000_2000);
    rd_chk("R7 clear disabled bit", 12'h430, 0);
  endtask

  task automatic t_collision();
    wr(12'h43C, 32'hFFFF_FFFF);
    wr(12'h438, 32'h0000_2000);
    @(negedge clk); drv = 0;
    tick();
    wr(12'h434, 32'hFFFF_FFFF);
    @(negedge clk); drv = 1;
    tick();
    chk("R9 irq on rise", {31'b0, irq_misc_o}, 1);
    @(negedge clk); drv = 0;
    @(negedge clk); drv = 1; addr = 12'h434; wdata = 32'h0000_2000; wr_en = 1;
    @(negedge clk); wr_en = 0;
    rd_chk("R8 edge beats clear", 12'h430, 32'h0000_2020);
    chk("R8 irq held", {31'b0, irq_misc_o}, 1);
    wr(12'h434, 32'hFFFF_FFFF);
  endtask

  task automatic t_unmapped();
    rd_chk("R10 addr 0x000", 12'h000, 0);
    rd_chk("R10 addr 0x100", 12'h100, 0);
    rd_chk("R10 addr 0x440", 12'h440, 0);
    wr(12'h028, 32'hFFFF_FFFE);
    rd_chk("R10 main upper bits", 12'h028, 0);
    wr(12'h010, 32'hFFFE_FFFF);
    rd_chk("R10 sysconfig other bits", 12'h010, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_edges();
    t_otg_dma();
    t_core();
    t_enable();
    t_masked();
    t_collision();
    t_unmapped();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule